// File: doc/BRIEF.md
# Multi-Buffer SPI Sequencer with Overwrite Guard

This block is an SPI master that walks a small table of transfer entries. Each entry has a 16-bit control word and a data word. A single pulse on `trig` starts one pass over entries 0 to N-1, where N is the programmed group length. Each received word is written into the receive slot with the same index as its entry. Each receive slot keeps an empty flag and an overwrite flag. When a word lands in a slot the host has not yet read, the block records the overwrite in that slot. It also sets a global overwrite flag and stores the slot index in a register.

Each entry carries a buffer mode:

- Continuous mode transfers the entry on every pass, whether or not its slot has been read.
- Suspend mode stops the sequencer at that entry until the host has emptied the matching slot, so no overwrite can happen.
- A disabled mode skips the entry.

Chip-select hold, a word gap and bit order are also chosen per entry. `irq` signals group completion or a pending overwrite.

The controller is a finite-state machine with six states:

- **S_IDLE**: waits for `trig`. A trigger with group length 0 completes at once.
- **S_FETCH**: decodes the current entry. It moves to S_ADV for a skipped entry, to S_WAIT when a suspend entry finds its slot full, and otherwise starts the shift engine and moves to S_XFER.
- **S_WAIT**: moves to S_XFER, starting the engine, once the slot reads empty.
- **S_XFER**: on the engine's word-done pulse, writes the slot. It moves to S_GAP when the gap is enabled and the gap count is nonzero, otherwise to S_ADV.
- **S_GAP**: counts the idle time, then moves to S_ADV.
- **S_ADV**: returns to S_IDLE after the last entry and raises group-done. Otherwise it steps the index and returns to S_FETCH.

Top module: `mbs_spi_seq`

## Requirements
- R1: After reset:
  - every receive slot reads with bit 14 (empty) set and bit 15 clear;
  - the status register, group length, overwrite index and word gap read 0;
  - all `spi_cs_n` lines are high;
  - `spi_sclk` and `irq` are low.
- R2: Group length and trigger behaviour:
  - Group length is register 0 (`host_sel`=3, `host_idx`=0).
  - A `trig` pulse in S_IDLE shifts the data of entries 0..N-1 out in index order, 8 bits per word, MSB first by default.
  - SPI mode 0 is used: `spi_sclk` idles low, `spi_mosi` is set up before each rising edge, and `spi_miso` is sampled on it.
  - After the last word, status bit 1 (done) is set and busy (status bit 2) drops.
  - A `trig` that arrives while busy is ignored.
- R3: Control bit 8 set makes the word go out LSB first. The word is still stored in natural bit order.
- R4: Receive slot empty flag:
  - Writing a received word clears the slot's empty flag (bit 14).
  - A host read with `host_rd` (`host_sel`=2) sets the empty flag again.
  - The slot data sits in bits 7:0.
- R5: Overwrite capture:
  - A word written into a slot whose empty flag is 0 sets that slot's overwrite bit (bit 15).
  - It also sets status bit 0.
  - It loads the slot index into register 2.
- R6: Overwrite clearing:
  - Writing 1 to status bit 0 clears the global overwrite flag.
  - Writing 1 to status bit 1 clears done.
  - A host read of a slot clears that slot's overwrite bit.
- R7: Buffer mode 5 (bits 15:13) waits, with no transfer and chip selects high, until the slot is empty. In this mode no overwrite is recorded.
- R8: Buffer mode 4 transfers the entry on every pass even if its slot is unread.
- R9: Buffer mode 0 skips the entry. No word is sent and its slot is left untouched.
- R10: Chip select behaviour:
  - Control bits 1:0 choose which active-low chip select is driven during the word, and at most one is low at any time.
  - With bit 12 set, the line stays low into the next entry. Otherwise it is released after the word.
  - All lines are released when the group ends.
- R11: With control bit 10 set, the word is followed by an idle time of G SCLK periods. G is held in register 3, and one SCLK period is 4 clock cycles by default.
- R12: Interrupt and vector:
  - `irq` is high while the overwrite flag or done is set.
  - Status bits 5:4 read 1 when an overwrite is pending, else 2 when done is set, else 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (pops a receive slot) |
| host_sel | input | 2 | Region: 0 control, 1 data, 2 receive slot, 3 register |
| host_idx | input | IDX_W | Entry, slot or register index |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data (combinational) |
| trig | input | 1 | Start one pass of the group |
| spi_sclk | output | 1 | SPI clock |
| spi_mosi | output | 1 | SPI data out |
| spi_miso | input | 1 | SPI data in |
| spi_cs_n | output | NCS | Active-low chip selects |
| irq | output | 1 | Interrupt request |

## Verification
With MOSI looped back to MISO, the bench sweeps every group length from one to four, using distinct data and chip-select patterns for each length. This separates errors in ordering, indexing and chip-select decoding. It then contrasts continuous and suspend entries over slots that are already full. The continuous run must overwrite and record the last index. The suspend run must stall entry by entry as each slot is read. Pairs of runs that differ only in hold, gap or bit-order bits are compared against each other, so each per-entry option is measured by the difference it alone makes.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_WAIT,
        S_XFER,
        S_GAP,
        S_ADV
    } seq_state_t;

    localparam logic [2:0] MODE_SKIP = 3'd0;
    localparam logic [2:0] MODE_CONT = 3'd4;
    localparam logic [2:0] MODE_SUSP = 3'd5;

    localparam logic [1:0] SEL_TXC = 2'd0;
    localparam logic [1:0] SEL_TXD = 2'd1;
    localparam logic [1:0] SEL_RX  = 2'd2;
    localparam logic [1:0] SEL_REG = 2'd3;

    localparam int REG_GLEN  = 0;
    localparam int REG_STAT  = 1;
    localparam int REG_OADDR = 2;
    localparam int REG_GAP   = 3;

    localparam int CB_HOLD = 12;
    localparam int CB_WD   = 10;
    localparam int CB_LSB  = 8;
endpackage

// File: rtl/mbs_shift.sv
module mbs_shift #(
    parameter int W    = 8,
    parameter int HALF = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         lsb_first,
    input  logic [W-1:0] tx_word,
    input  logic         miso,
    output logic         sclk,
    output logic         mosi,
    output logic         done,
    output logic [W-1:0] rx_word
);
    localparam int DIV_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int BIT_W = $clog2(W);

    logic [W-1:0]     tx_rev;
    logic [W-1:0]     sh_q;
    logic [W-1:0]     rx_raw;
    logic             lsb_q;
    logic             busy_q;
    logic [DIV_W-1:0] div_q;
    logic [BIT_W-1:0] bit_q;

    for (genvar i = 0; i < W; i++) begin : g_rev
        assign tx_rev[i]  = tx_word[W-1-i];
        assign rx_word[i] = lsb_q ? rx_raw[W-1-i] : rx_raw[i];
    end

    assign mosi = busy_q & sh_q[W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            rx_raw <= '0;
            lsb_q  <= 1'b0;
            busy_q <= 1'b0;
            div_q  <= '0;
            bit_q  <= '0;
            sclk   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy_q) begin
                sh_q   <= lsb_first ? tx_rev : tx_word;
                lsb_q  <= lsb_first;
                busy_q <= 1'b1;
                div_q  <= '0;
                bit_q  <= '0;
                sclk   <= 1'b0;
            end else if (busy_q) begin
                if (div_q == DIV_W'(HALF - 1)) begin
                    div_q <= '0;
                    if (!sclk) begin
                        sclk   <= 1'b1;
                        rx_raw <= {rx_raw[W-2:0], miso};
                    end else begin
                        sclk <= 1'b0;
                        if (bit_q == BIT_W'(W - 1)) begin
                            busy_q <= 1'b0;
                            done   <= 1'b1;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                            sh_q  <= {sh_q[W-2:0], 1'b0};
                        end
                    end
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end
        end
    end

    // R2
    sclk_rest_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !sclk);
endmodule

// File: rtl/mbs_rxbuf.sv
module mbs_rxbuf #(
    parameter int ENTRIES = 4,
    parameter int W       = 8,
    parameter int IDX_W   = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr,
    input  logic [IDX_W-1:0]            waddr,
    input  logic [W-1:0]                wdata,
    input  logic                        rd,
    input  logic [IDX_W-1:0]            raddr,
    input  logic                        clr_ovr,
    output logic [ENTRIES-1:0]          empty_q,
    output logic [ENTRIES-1:0]          ovr_q,
    output logic [ENTRIES-1:0][W-1:0]   data_q,
    output logic                        glob_ovr_q,
    output logic [IDX_W-1:0]            ovr_addr_q
);
    logic             clash;
    logic [IDX_W-1:0] wa_d;

    assign clash = wr && !empty_q[waddr];

    for (genvar s = 0; s < ENTRIES; s++) begin : g_slot
        logic         hit_w;
        logic         hit_r;
        logic         emp;
        logic         ovr;
        logic [W-1:0] dat;

        assign hit_w = wr && (waddr == IDX_W'(s));
        assign hit_r = rd && (raddr == IDX_W'(s));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                emp <= 1'b1;
                ovr <= 1'b0;
                dat <= '0;
            end else if (hit_w) begin
                dat <= wdata;
                emp <= 1'b0;
                if (!emp) ovr <= 1'b1;
            end else if (hit_r) begin
                emp <= 1'b1;
                ovr <= 1'b0;
            end
        end

        assign empty_q[s] = emp;
        assign ovr_q[s]   = ovr;
        assign data_q[s]  = dat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            glob_ovr_q <= 1'b0;
            ovr_addr_q <= '0;
            wa_d       <= '0;
        end else begin
            wa_d <= waddr;
            if (clash) begin
                glob_ovr_q <= 1'b1;
                ovr_addr_q <= waddr;
            end else if (clr_ovr) begin
                glob_ovr_q <= 1'b0;
            end
        end
    end

    // R4
    slot_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> !empty_q[wa_d]);
    // R5
    slot_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clash |=> (ovr_q[wa_d] && glob_ovr_q));
    // R6
    ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ovr && !clash) |=> !glob_ovr_q);
endmodule

// File: rtl/mbs_seq.sv
module mbs_seq
    import mbs_pkg::*;
#(
    parameter int IDX_W    = 2,
    parameter int NCS      = 4,
    parameter int CSN_W    = 2,
    parameter int GAP_W    = 4,
    parameter int SCLK_PER = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic [IDX_W:0]   glen,
    input  logic [2:0]       mode,
    input  logic             hold,
    input  logic             wd_en,
    input  logic [CSN_W-1:0] csn,
    input  logic [GAP_W-1:0] gap,
    input  logic             slot_empty,
    input  logic             eng_done,
    output logic [IDX_W-1:0] idx_q,
    output logic             eng_start,
    output logic             rx_wr,
    output logic             grp_done,
    output logic             busy,
    output logic [NCS-1:0]   cs_n
);
    localparam int CNT_W = GAP_W + $clog2(SCLK_PER) + 1;

    seq_state_t       st_q, st_d;
    logic             skip, suspend, last;
    logic [CNT_W-1:0] gcnt_q;
    logic [CNT_W-1:0] gap_tgt;
    logic             cs_on_q;
    logic [CSN_W-1:0] cs_num_q;

    assign skip    = (mode == MODE_SKIP);
    assign suspend = (mode == MODE_SUSP);
    assign last    = ({1'b0, idx_q} == glen - 1'b1);
    assign gap_tgt = CNT_W'(gap) * CNT_W'(SCLK_PER);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:  if (trig && glen != '0) st_d = S_FETCH;
            S_FETCH: begin
                if (skip)                       st_d = S_ADV;
                else if (suspend && !slot_empty) st_d = S_WAIT;
                else                             st_d = S_XFER;
            end
            S_WAIT:  if (slot_empty) st_d = S_XFER;
            S_XFER:  if (eng_done) st_d = (wd_en && gap != '0) ? S_GAP : S_ADV;
            S_GAP:   if (gcnt_q == gap_tgt - 1'b1) st_d = S_ADV;
            S_ADV:   st_d = last ? S_IDLE : S_FETCH;
            default: st_d = S_IDLE;
        endcase
    end

    always_comb begin
        eng_start = 1'b0;
        rx_wr     = 1'b0;
        grp_done  = 1'b0;
        unique case (st_q)
            S_IDLE:  grp_done  = trig && (glen == '0);
            S_FETCH: eng_start = !skip && !(suspend && !slot_empty);
            S_WAIT:  eng_start = slot_empty;
            S_XFER:  rx_wr     = eng_done;
            S_ADV:   grp_done  = last;
            default: ;
        endcase
    end

    assign busy = (st_q != S_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q    <= '0;
            gcnt_q   <= '0;
            cs_on_q  <= 1'b0;
            cs_num_q <= '0;
        end else begin
            if (st_q == S_IDLE && trig)        idx_q <= '0;
            else if (st_q == S_ADV && !last)   idx_q <= idx_q + 1'b1;

            if (st_q == S_GAP) gcnt_q <= gcnt_q + 1'b1;
            else               gcnt_q <= '0;

            if (eng_start) begin
                cs_on_q  <= 1'b1;
                cs_num_q <= csn;
            end else if (rx_wr && !hold) begin
                cs_on_q <= 1'b0;
            end else if (st_q == S_ADV && last) begin
                cs_on_q <= 1'b0;
            end
        end
    end

    for (genvar c = 0; c < NCS; c++) begin : g_cs
        assign cs_n[c] = !(cs_on_q && cs_num_q == CSN_W'(c));
    end

    // R10
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));
    // R10
    cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grp_done |=> (&cs_n));
    // R7
    suspend_no_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_wr && suspend) |-> slot_empty);
endmodule

// File: rtl/mbs_spi_seq.sv
module mbs_spi_seq
    import mbs_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int DATA_W  = 8,
    parameter int NCS     = 4,
    parameter int HALF    = 2,
    parameter int GAP_W   = 4,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [1:0]       host_sel,
    input  logic [IDX_W-1:0] host_idx,
    input  logic [15:0]      host_wdata,
    output logic [15:0]      host_rdata,
    input  logic             trig,
    output logic             spi_sclk,
    output logic             spi_mosi,
    input  logic             spi_miso,
    output logic [NCS-1:0]   spi_cs_n,
    output logic             irq
);
    localparam int CSN_W    = $clog2(NCS);
    localparam int SCLK_PER = 2 * HALF;

    logic [ENTRIES-1:0][15:0]       txc_q;
    logic [ENTRIES-1:0][DATA_W-1:0] txd_q;
    logic [IDX_W:0]                 glen_q;
    logic [GAP_W-1:0]               gap_q;
    logic                           done_q;

    logic [IDX_W-1:0]               idx;
    logic [15:0]                    cur_c;
    logic                           eng_start, eng_done, rx_wr, grp_done, busy;
    logic [DATA_W-1:0]              rx_word;
    logic [ENTRIES-1:0]             empty, ovr;
    logic [ENTRIES-1:0][DATA_W-1:0] rx_data;
    logic                           glob_ovr;
    logic [IDX_W-1:0]               ovr_addr;
    logic                           reg_wr, stat_wr, rx_pop;
    logic [1:0]                     vec;

    assign cur_c   = txc_q[idx];
    assign reg_wr  = host_wr && host_sel == SEL_REG;
    assign stat_wr = reg_wr && host_idx == IDX_W'(REG_STAT);
    assign rx_pop  = host_rd && host_sel == SEL_RX;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txc_q  <= '0;
            txd_q  <= '0;
            glen_q <= '0;
            gap_q  <= '0;
            done_q <= 1'b0;
        end else begin
            if (host_wr && host_sel == SEL_TXC) txc_q[host_idx] <= host_wdata;
            if (host_wr && host_sel == SEL_TXD) txd_q[host_idx] <= host_wdata[DATA_W-1:0];
            if (reg_wr && host_idx == IDX_W'(REG_GLEN)) begin
                if (host_wdata > 16'(ENTRIES)) glen_q <= (IDX_W+1)'(ENTRIES);
                else                           glen_q <= host_wdata[IDX_W:0];
            end
            if (reg_wr && host_idx == IDX_W'(REG_GAP)) gap_q <= host_wdata[GAP_W-1:0];
            if (grp_done)                          done_q <= 1'b1;
            else if (stat_wr && host_wdata[1])     done_q <= 1'b0;
        end
    end

    mbs_seq #(
        .IDX_W(IDX_W), .NCS(NCS), .CSN_W(CSN_W), .GAP_W(GAP_W), .SCLK_PER(SCLK_PER)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .trig(trig), .glen(glen_q),
        .mode(cur_c[15:13]), .hold(cur_c[CB_HOLD]), .wd_en(cur_c[CB_WD]),
        .csn(cur_c[CSN_W-1:0]), .gap(gap_q), .slot_empty(empty[idx]),
        .eng_done(eng_done), .idx_q(idx), .eng_start(eng_start), .rx_wr(rx_wr),
        .grp_done(grp_done), .busy(busy), .cs_n(spi_cs_n)
    );

    mbs_shift #(.W(DATA_W), .HALF(HALF)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(eng_start), .lsb_first(cur_c[CB_LSB]),
        .tx_word(txd_q[idx]), .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi),
        .done(eng_done), .rx_word(rx_word)
    );

    mbs_rxbuf #(.ENTRIES(ENTRIES), .W(DATA_W), .IDX_W(IDX_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .wr(rx_wr), .waddr(idx), .wdata(rx_word),
        .rd(rx_pop), .raddr(host_idx), .clr_ovr(stat_wr && host_wdata[0]),
        .empty_q(empty), .ovr_q(ovr), .data_q(rx_data),
        .glob_ovr_q(glob_ovr), .ovr_addr_q(ovr_addr)
    );

    assign vec = glob_ovr ? 2'd1 : (done_q ? 2'd2 : 2'd0);
    assign irq = glob_ovr | done_q;

    always_comb begin
        host_rdata = '0;
        unique case (host_sel)
            SEL_TXC: host_rdata = txc_q[host_idx];
            SEL_TXD: host_rdata[DATA_W-1:0] = txd_q[host_idx];
            SEL_RX: begin
                host_rdata[15]         = ovr[host_idx];
                host_rdata[14]         = empty[host_idx];
                host_rdata[DATA_W-1:0] = rx_data[host_idx];
            end
            default: begin
                if (host_idx == IDX_W'(REG_GLEN)) host_rdata[IDX_W:0] = glen_q;
                else if (host_idx == IDX_W'(REG_STAT)) begin
                    host_rdata[0]   = glob_ovr;
                    host_rdata[1]   = done_q;
                    host_rdata[2]   = busy;
                    host_rdata[5:4] = vec;
                end
                else if (host_idx == IDX_W'(REG_OADDR)) host_rdata[IDX_W-1:0] = ovr_addr;
                else host_rdata[GAP_W-1:0] = gap_q;
            end
        endcase
    end

    // R10
    sclk_framed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> !(&spi_cs_n));
    // R12
    irq_on_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_wr && !empty[idx]) |=> irq);
endmodule

// File: tb/mbs_spi_seq_tb.sv
module mbs_spi_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [1:0]  host_sel = 2'd0;
    logic [1:0]  host_idx = 2'd0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        trig = 1'b0;
    logic        spi_sclk, spi_mosi;
    logic [3:0]  spi_cs_n;
    logic        irq;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    mbs_spi_seq u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_sel(host_sel), .host_idx(host_idx), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .trig(trig), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_mosi), .spi_cs_n(spi_cs_n), .irq(irq)
    );

    // wire-order word capture on rising SCLK
    logic [7:0] wlog [256];
    logic [3:0] cslog [256];
    int wcnt = 0, nb = 0, rel = 0;
    logic [7:0] sh = '0;
    logic prev_all = 1'b1;

    always @(posedge spi_sclk) begin
        sh = {sh[6:0], spi_mosi};
        nb = nb + 1;
        if (nb == 8) begin
            wlog[wcnt % 256]  = sh;
            cslog[wcnt % 256] = ~spi_cs_n;
            wcnt = wcnt + 1;
            nb = 0;
        end
    end

    always @(posedge clk) begin
        if ((&spi_cs_n) && !prev_all) rel = rel + 1;
        prev_all = &spi_cs_n;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hwrite(input logic [1:0] s, input int i, input logic [15:0] d);
        @(negedge clk);
        host_sel = s; host_idx = i[1:0]; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(input logic [1:0] s, input int i, input bit pop, output logic [15:0] d);
        @(negedge clk);
        host_sel = s; host_idx = i[1:0]; host_rd = pop;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic pulse_trig();
        @(negedge clk); trig = 1'b1;
        @(negedge clk); trig = 1'b0;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        @(negedge clk); host_sel = 2'd3; host_idx = 2'd1;
        while (1) begin
            @(negedge clk);
            #1;
            cyc++;
            if (host_rdata[1]) break;
            if (cyc > 5000) begin
                chk(0, "R2 done timeout", 0, 1);
                break;
            end
        end
    endtask

    function automatic logic [15:0] ctl(input logic [2:0] m, input bit hold, input bit wd,
                                        input bit lsb, input int cs);
        return {m, hold, 1'b0, wd, 1'b0, lsb, 6'b0, cs[1:0]};
    endfunction

    function automatic logic [7:0] rev8(input logic [7:0] v);
        logic [7:0] r;
        for (int b = 0; b < 8; b++) r[b] = v[7-b];
        return r;
    endfunction

    task automatic run(input int g, output int cyc);
        hwrite(2'd3, 0, 16'(g));
        pulse_trig();
        wait_done(cyc);
        hwrite(2'd3, 1, 16'h0003);
    endtask

    task automatic drain();
        logic [15:0] d;
        for (int i = 0; i < 4; i++) hread(2'd2, i, 1, d);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] d;
        int cyc, c0, c1, c2, base, r0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        hread(2'd3, 1, 0, d); chk(d == 16'h0000, "R1 status", d, 0);
        hread(2'd3, 0, 0, d); chk(d == 16'h0000, "R1 glen", d, 0);
        for (int i = 0; i < 4; i++) begin
            hread(2'd2, i, 0, d); chk(d == 16'h4000, "R1 slot", d, 16'h4000);
        end
        chk(spi_cs_n == 4'hF && !spi_sclk && !irq, "R1 pins", {spi_cs_n, spi_sclk, irq}, 6'h3C);

        // R2 R4 R10 R12: sweep group lengths 1..4
        for (int g = 1; g <= 4; g++) begin
            for (int i = 0; i < 4; i++) begin
                hwrite(2'd0, i, ctl(3'd4, 0, 0, 0, (i + g) % 4));
                hwrite(2'd1, i, 16'((8'h3C + 37 * i + 11 * g) & 8'hFF));
            end
            base = wcnt; r0 = rel;
            hwrite(2'd3, 0, 16'(g));
            pulse_trig();
            wait_done(cyc);
            hread(2'd3, 1, 0, d); chk(d == 16'h0022, "R12 done vector", d, 16'h22);
            chk(irq, "R12 irq on done", irq, 1);
            chk(wcnt - base == g, "R2 word count", wcnt - base, g);
            chk(rel - r0 == g, "R10 release per word", rel - r0, g);
            for (int i = 0; i < g; i++) begin
                chk(wlog[(base + i) % 256] == 8'((8'h3C + 37 * i + 11 * g) & 8'hFF), "R2 wire order",
                    wlog[(base + i) % 256], (8'h3C + 37 * i + 11 * g) & 8'hFF);
                chk(cslog[(base + i) % 256] == 4'(1 << ((i + g) % 4)), "R10 cs select",
                    cslog[(base + i) % 256], 1 << ((i + g) % 4));
                hread(2'd2, i, 1, d);
                chk(d == 16'((8'h3C + 37 * i + 11 * g) & 8'hFF), "R4 slot full", d, (8'h3C + 37 * i + 11 * g) & 8'hFF);
                hread(2'd2, i, 0, d);
                chk(d[15:14] == 2'b01, "R4 slot emptied", d[15:14], 1);
            end
            hwrite(2'd3, 1, 16'h0002);
            hread(2'd3, 1, 0, d); chk(d == 16'h0000 && !irq, "R6 done clear", d, 0);
        end

        // R3 LSB first
        hwrite(2'd0, 0, ctl(3'd4, 0, 0, 1, 0));
        hwrite(2'd1, 0, 16'h00B1);
        base = wcnt;
        run(1, cyc);
        chk(wlog[base % 256] == rev8(8'hB1), "R3 lsb wire", wlog[base % 256], rev8(8'hB1));
        hread(2'd2, 0, 1, d); chk(d[7:0] == 8'hB1, "R3 lsb stored", d[7:0], 8'hB1);

        // R5 R6 R8 overwrite in continuous mode
        for (int i = 0; i < 3; i++) begin
            hwrite(2'd0, i, ctl(3'd4, 0, 0, 0, 1));
            hwrite(2'd1, i, 16'(8'h50 + i));
        end
        run(3, cyc);
        for (int i = 0; i < 3; i++) hwrite(2'd1, i, 16'(8'hA0 + i));
        hwrite(2'd3, 0, 16'd3);
        base = wcnt;
        pulse_trig();
        wait_done(cyc);
        chk(wcnt - base == 3, "R8 continuous sends", wcnt - base, 3);
        hread(2'd3, 1, 0, d); chk(d[0] == 1'b1 && d[5:4] == 2'd1, "R5 R12 status ovr", d, 16'h13);
        chk(irq, "R12 irq ovr", irq, 1);
        hread(2'd3, 2, 0, d); chk(d == 16'd2, "R5 ovr index", d, 2);
        hread(2'd2, 1, 1, d); chk(d == 16'h80A1, "R5 slot ovr bit", d, 16'h80A1);
        hread(2'd2, 1, 0, d); chk(d == 16'h40A1, "R6 slot ovr cleared", d, 16'h40A1);
        hwrite(2'd3, 1, 16'h0003);
        hread(2'd3, 1, 0, d); chk(d == 16'h0000 && !irq, "R6 global clear", d, 0);
        drain();

        // R7 suspend mode
        for (int i = 0; i < 2; i++) begin
            hwrite(2'd0, i, ctl(3'd4, 0, 0, 0, 0));
            hwrite(2'd1, i, 16'(8'h11 + i));
        end
        run(2, cyc);
        for (int i = 0; i < 2; i++) begin
            hwrite(2'd0, i, ctl(3'd5, 0, 0, 0, 0));
            hwrite(2'd1, i, 16'(8'hC4 + i));
        end
        base = wcnt;
        hwrite(2'd3, 0, 16'd2);
        pulse_trig();
        repeat (200) @(negedge clk);
        chk(wcnt == base, "R7 stalled", wcnt - base, 0);
        chk(&spi_cs_n, "R7 cs idle in wait", spi_cs_n, 4'hF);
        hread(2'd3, 1, 0, d); chk(d[2:0] == 3'b100, "R7 busy waiting", d[2:0], 3'b100);
        hread(2'd2, 0, 1, d);
        repeat (200) @(negedge clk);
        chk(wcnt - base == 1, "R7 one released", wcnt - base, 1);
        hread(2'd2, 1, 1, d);
        wait_done(cyc);
        chk(wcnt - base == 2, "R7 both sent", wcnt - base, 2);
        hread(2'd3, 1, 0, d); chk(d[0] == 1'b0, "R7 no overwrite", d[0], 0);
        hread(2'd2, 0, 1, d); chk(d == 16'h00C4, "R7 slot content", d, 16'h00C4);
        hwrite(2'd3, 1, 16'h0003);
        drain();

        // R9 skip mode
        hwrite(2'd0, 0, ctl(3'd4, 0, 0, 0, 0)); hwrite(2'd1, 0, 16'h0061);
        hwrite(2'd0, 1, ctl(3'd0, 0, 0, 0, 0)); hwrite(2'd1, 1, 16'h0062);
        hwrite(2'd0, 2, ctl(3'd4, 0, 0, 0, 0)); hwrite(2'd1, 2, 16'h0063);
        base = wcnt;
        run(3, cyc);
        chk(wcnt - base == 2, "R9 skip count", wcnt - base, 2);
        chk(wlog[(base + 1) % 256] == 8'h63, "R9 next after skip", wlog[(base + 1) % 256], 8'h63);
        hread(2'd2, 1, 1, d); chk(d[15:14] == 2'b01, "R9 slot untouched", d[15:14], 1);
        drain();

        // R10 chip select hold
        hwrite(2'd0, 0, ctl(3'd4, 1, 0, 0, 2));
        hwrite(2'd0, 1, ctl(3'd4, 1, 0, 0, 2));
        hwrite(2'd0, 2, ctl(3'd4, 0, 0, 0, 2));
        r0 = rel;
        run(3, cyc);
        chk(rel - r0 == 1, "R10 hold keeps cs", rel - r0, 1);
        chk(&spi_cs_n, "R10 released at end", spi_cs_n, 4'hF);
        drain();

        // R11 word delay
        hwrite(2'd3, 3, 16'd3);
        hwrite(2'd0, 0, ctl(3'd4, 0, 0, 0, 0));
        hwrite(2'd0, 1, ctl(3'd4, 0, 0, 0, 0));
        run(2, c0); drain();
        hwrite(2'd0, 0, ctl(3'd4, 0, 1, 0, 0));
        hwrite(2'd0, 1, ctl(3'd4, 0, 1, 0, 0));
        run(2, c1); drain();
        chk(c1 - c0 == 24, "R11 gap length", c1 - c0, 24);
        hwrite(2'd3, 3, 16'd0);
        run(2, c2); drain();
        chk(c2 == c0, "R11 zero gap", c2, c0);

        // R2 trigger while busy is ignored
        base = wcnt;
        hwrite(2'd3, 0, 16'd2);
        pulse_trig();
        repeat (10) @(negedge clk);
        pulse_trig();
        wait_done(cyc);
        hwrite(2'd3, 1, 16'h0003);
        repeat (150) @(negedge clk);
        chk(wcnt - base == 2, "R2 busy trigger ignored", wcnt - base, 2);
        hread(2'd3, 1, 0, d); chk(d[2:0] == 3'b000, "R2 idle after", d[2:0], 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule